// File: doc/BRIEF.md
# Fan PWM Generator Channel

This block drives one cooling fan with a programmable pulse train. The input clock passes through a two-stage prescaler: a power-of-two stage followed by a linear stage. The prescaled tick advances an 8-bit cycle counter. Within each cycle the output rises when the counter reaches a programmed rising point and falls when it reaches a programmed falling point. Software configures the channel through two 32-bit registers, a control word and a duty word, using a simple write strobe and a register select. The selected register can be read back at any time.

The output stage can invert the pin, drive it open-drain, or hold a static level while the clock stage is stopped. Duty updates are normally double-buffered, so a new duty word takes effect only at the start of the next cycle. That buffering can be switched off. A watchdog event input copies a preset 8-bit value, stored in the duty word, over either the falling point or the rising point. This lets a safety controller push the fan to a known duty without software.

Top module: `fan_pwm_chan`

## Requirements
- R1: After reset, pwm_o is 0, pwm_oe_no is 1, and both registers read as zero.
- R2: Register layout and the basic waveform. Control bit 16 enables the clock stage and bit 12 enables the pin. The duty word holds the period in [31:24], the preset watchdog value in [23:16], the falling point in [15:8] and the rising point in [7:0]. While both enable bits are set, the counter starts from 0 and advances once per prescaled tick, wrapping to 0 after it reaches the period, so a cycle lasts period+1 ticks. The logical level becomes 1 in the cycle where the counter equals the rising point, becomes 0 where it equals the falling point, and otherwise keeps its previous value. Reset leaves this level at 0.
- R3: If the rising and falling points are equal, the logical level is 0 for the whole cycle.
- R4: The prescaler divides the clock by 2^H·(L+1). H is control[11:8], so 0 gives 1 and 15 gives 32768. L is control[7:0], so 0 gives 1 and 255 gives 256.
- R5: With control bit 12 clear, pwm_o is 0 and pwm_oe_no is 1, whatever the other bits are.
- R6: With bit 12 set and bit 16 clear, the counter, the prescaler and the held level all freeze. pwm_o is then control bit 15 XOR control bit 14. A later enable of the clock stage resumes from the frozen state.
- R7: Control bit 14 inverts the waveform on pwm_o.
- R8: When bit 12 is set and control bit 13 is clear (push-pull), pwm_oe_no is 0. When bit 12 and bit 13 are both set (open-drain), pwm_oe_no equals pwm_o, so the pin is driven only while it is low.
- R9: With control bit 17 clear, a new duty word is used from the first counter value 0 after the write. With bit 17 set, it is used from the cycle after the write.
- R10: When control bit 18 is set, a cycle with wdt_evt_i high copies duty[23:16] into duty[15:8] if control bit 19 is 1, or into duty[7:0] if bit 19 is 0. The change is visible on readback and follows the R9 timing. With bit 18 clear, the event has no effect.
- R11: reg_sel_i=0 selects control and reg_sel_i=1 selects duty, both for writes on reg_we_i and for reg_rdata_o. Control bits [31:20] read as 0. All 32 duty bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_sel_i | input | 1 | Register select: 0 control, 1 duty |
| reg_wdata_i | input | 32 | Write data |
| wdt_evt_i | input | 1 | Watchdog event, one cycle per event |
| reg_rdata_o | output | 32 | Readback of the selected register |
| pwm_o | output | 1 | PWM pin level |
| pwm_oe_no | output | 1 | Pin output enable, active low |

## Verification
The assertions assume the following about the inputs:
- wdt_evt_i is a single-cycle pulse.
- Software does not write the duty register in the same cycle as a watchdog event when it expects the event alone to change the stored value.
- The prescaler fields describe a real division.

The stimulus follows these rules. Each watchdog event and each register write lasts exactly one clock, and writes and events never coincide. Every waveform scenario starts from a fresh reset, so the expected counter phase and held level are known from the cycle the enabling control write lands.

// File: rtl/fpwm_pkg.sv
`timescale 1ns/1ps
package fpwm_pkg;
  localparam int REG_W     = 32;
  localparam int CNT_W     = 8;
  localparam int DIVH_W    = 4;
  localparam int DIVL_W    = 8;
  localparam int CTRL_USED = 12 + 8;

  // duty word field offsets (software-visible)
  localparam int PER_LSB  = 24;
  localparam int WDT_LSB  = 16;
  localparam int FALL_LSB = 8;
  localparam int RISE_LSB = 0;

  // packed to match control[19:0]
  typedef struct packed {
    logic              wdt_sel;
    logic              wdt_en;
    logic              sync_dis;
    logic              clk_en;
    logic              lvl;
    logic              inv;
    logic              od;
    logic              pin_en;
    logic [DIVH_W-1:0] div_h;
    logic [DIVL_W-1:0] div_l;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] fall;
    logic [CNT_W-1:0] rise;
  } wave_cfg_t;
endpackage

// File: rtl/fpwm_regs.sv
`timescale 1ns/1ps
module fpwm_regs
  import fpwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             wdt_i,
  input  logic             load_act_i,
  output ctrl_t            ctrl_o,
  output wave_cfg_t        act_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [CTRL_USED-1:0] ctrl_q;
  logic [REG_W-1:0]     duty_q, duty_d;
  wave_cfg_t            act_q;

  assign ctrl_o = ctrl_t'(ctrl_q);
  assign act_o  = act_q;

  always_comb begin
    duty_d = (we_i && sel_i) ? wdata_i : duty_q;
    if (wdt_i && ctrl_o.wdt_en) begin
      if (ctrl_o.wdt_sel) duty_d[FALL_LSB +: CNT_W] = duty_d[WDT_LSB +: CNT_W];
      else                duty_d[RISE_LSB +: CNT_W] = duty_d[WDT_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      duty_q <= '0;
      act_q  <= '0;
    end else begin
      if (we_i && !sel_i) ctrl_q <= wdata_i[CTRL_USED-1:0];
      duty_q <= duty_d;
      // shadow copy: the counter logic only ever sees act_q
      if (load_act_i)
        act_q <= {duty_q[PER_LSB +: CNT_W], duty_q[FALL_LSB +: CNT_W], duty_q[RISE_LSB +: CNT_W]};
    end
  end

  assign rdata_o = sel_i ? duty_q : {{(REG_W-CTRL_USED){1'b0}}, ctrl_q};

  assert_wdt_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_i && !ctrl_o.wdt_en && !we_i) |=> $stable(duty_q));

  assert_wdt_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_i && ctrl_o.wdt_en && ctrl_o.wdt_sel && !we_i)
      |=> duty_q[FALL_LSB +: CNT_W] == $past(duty_q[WDT_LSB +: CNT_W]));
endmodule

// File: rtl/fpwm_prescaler.sv
`timescale 1ns/1ps
module fpwm_prescaler #(
  parameter int DIVH_W = 4,
  parameter int DIVL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DIVH_W-1:0] div_h_i,
  input  logic [DIVL_W-1:0] div_l_i,
  output logic              tick_o
);
  localparam int PH_W = (1 << DIVH_W) - 1;

  logic [PH_W-1:0]   cnt_h_q, mask_h;
  logic [DIVL_W-1:0] cnt_l_q;
  logic              tick_h;

  assign mask_h = ~({PH_W{1'b1}} << div_h_i);
  assign tick_h = cnt_h_q >= mask_h;
  assign tick_o = run_i && tick_h && (cnt_l_q >= div_l_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_h_q <= '0;
      cnt_l_q <= '0;
    end else if (run_i) begin
      cnt_h_q <= tick_h ? '0 : cnt_h_q + 1'b1;
      if (tick_h) cnt_l_q <= (cnt_l_q >= div_l_i) ? '0 : cnt_l_q + 1'b1;
    end
  end

  assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (div_h_i != '0 || div_l_i != '0) && $stable(div_h_i) && $stable(div_l_i))
      |=> !tick_o);
endmodule

// File: rtl/fpwm_wave.sv
`timescale 1ns/1ps
module fpwm_wave
  import fpwm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      tick_i,
  input  logic      sync_dis_i,
  input  logic      clk_en_i,
  input  logic      pin_en_i,
  input  logic      inv_i,
  input  logic      od_i,
  input  logic      lvl_i,
  input  wave_cfg_t cfg_i,
  output logic      boundary_o,
  output logic      pwm_o,
  output logic      oe_no
);
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q, lvl_c, logic_lvl, pin_val;

  assign boundary_o = tick_i && (cnt_q >= cfg_i.period);

  // equal points force low; otherwise set on rise, clear on fall, else hold
  assign lvl_c = (cfg_i.rise != cfg_i.fall) &&
                 ((cnt_q == cfg_i.rise) || ((cnt_q != cfg_i.fall) && lvl_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= boundary_o ? '0 : cnt_q + 1'b1;
      if (run_i)  lvl_q <= lvl_c;
    end
  end

  assign logic_lvl = clk_en_i ? lvl_c : lvl_i;
  assign pin_val   = logic_lvl ^ inv_i;
  assign pwm_o     = pin_en_i & pin_val;
  assign oe_no     = !pin_en_i || (od_i && pin_val);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q) && $stable(lvl_q));

  assert_eq_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cfg_i.rise == cfg_i.fall) |=> !lvl_q);

  assert_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !sync_dis_i && !$past(sync_dis_i) && !$stable(cfg_i))
      |-> cnt_q == '0);

  assert_od_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_en_i && od_i && pwm_o) |-> oe_no);

  assert_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_en_i |-> (!pwm_o && oe_no));
endmodule

// File: rtl/fan_pwm_chan.sv
`timescale 1ns/1ps
module fan_pwm_chan
  import fpwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             wdt_evt_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             pwm_o,
  output logic             pwm_oe_no
);
  ctrl_t     ctrl;
  wave_cfg_t act;
  logic      run, tick, boundary, load_act;

  assign run      = ctrl.clk_en && ctrl.pin_en;
  assign load_act = ctrl.sync_dis || !run || boundary;

  fpwm_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .wdt_i      (wdt_evt_i),
    .load_act_i (load_act),
    .ctrl_o     (ctrl),
    .act_o      (act),
    .rdata_o    (reg_rdata_o)
  );

  fpwm_prescaler #(.DIVH_W(DIVH_W), .DIVL_W(DIVL_W)) i_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .div_h_i (ctrl.div_h),
    .div_l_i (ctrl.div_l),
    .tick_o  (tick)
  );

  fpwm_wave i_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .sync_dis_i (ctrl.sync_dis),
    .clk_en_i   (ctrl.clk_en),
    .pin_en_i   (ctrl.pin_en),
    .inv_i      (ctrl.inv),
    .od_i       (ctrl.od),
    .lvl_i      (ctrl.lvl),
    .cfg_i      (act),
    .boundary_o (boundary),
    .pwm_o      (pwm_o),
    .oe_no      (pwm_oe_no)
  );
endmodule

// File: tb/test_fan_pwm_chan.sv
`timescale 1ns/1ps
module test_fan_pwm_chan;
  localparam logic [31:0] C_PIN = 32'h1 << 12, C_CLK = 32'h1 << 16, C_RUN = C_PIN | C_CLK;
  localparam logic [31:0] C_LVL = 32'h1 << 15, C_INV = 32'h1 << 14, C_OD = 32'h1 << 13;
  localparam logic [31:0] C_SDIS = 32'h1 << 17, C_WEN = 32'h1 << 18, C_WSEL = 32'h1 << 19;

  logic clk = 0, rst_n = 0, we = 0, sel = 0, wdt = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic pwm, oen;
  int checks = 0, fails = 0;

  typedef struct { logic pwm; logic oen; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  fan_pwm_chan i_fan_pwm_chan (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .wdt_evt_i(wdt), .reg_rdata_o(rdata), .pwm_o(pwm), .pwm_oe_no(oen));

  function automatic logic [31:0] duty(int p, int w, int f, int r);
    return {p[7:0], w[7:0], f[7:0], r[7:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: one expected item per falling clock edge
  initial forever begin
    @(negedge clk);
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, {30'b0, pwm, oen}, {30'b0, e.pwm, e.oen});
    end
  end

  task automatic do_reset();
    rst_n = 0; we = 0; wdt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic s, logic [31:0] d);
    @(negedge clk); we = 1; sel = s; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic pulse_wdt();
    @(negedge clk); wdt = 1;
    @(posedge clk); #1 wdt = 0;
  endtask

  task automatic rd(logic s, logic [31:0] exp, string tag);
    @(negedge clk); sel = s;
    #1 chk(tag, rdata, exp);
  endtask

  // expected waveform from the cycle after the enabling write, k = 0..n-1
  task automatic push_wave(logic [31:0] d_old, logic [31:0] d_new, int ks, int dv, int n,
                           bit inv, bit od, string tag);
    bit lvl = 0;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic [31:0] d;
      int p, r, f, c;
      bit pin;
      d = (k < ks) ? d_old : d_new;
      p = int'(d_old[31:24]); f = int'(d[15:8]); r = int'(d[7:0]);
      c = (k / dv) % (p + 1);
      if (r == f) lvl = 0;
      else if (c == r) lvl = 1;
      else if (c == f) lvl = 0;
      pin = lvl ^ inv;
      e.pwm = pin; e.oen = od ? pin : 1'b0; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic push_const(logic p, logic o, int n, string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.pwm = p; e.oen = o; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_basic(logic [31:0] d, logic [31:0] c, int dv, int n, string tag);
    do_reset();
    wr(1, d);
    wr(0, c | C_RUN);
    push_wave(d, d, n, dv, n, c[14], c[13], tag);
    drain();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 pwm_o", {31'b0, pwm}, 32'd0);
    chk("R1 pwm_oe_no", {31'b0, oen}, 32'd1);
    rd(0, 32'h0, "R1 ctrl read");
    rd(1, 32'h0, "R1 duty read");

    // R2 basic waveform, R3 equal points, R7 inversion, R8 drive modes
    run_basic(duty(9, 0, 6, 2), 32'h0, 1, 30, "R2 basic");
    run_basic(duty(4, 0, 1, 3), 32'h0, 1, 15, "R2 rise after fall");
    run_basic(duty(9, 0, 4, 4), 32'h0, 1, 20, "R3 equal points");
    run_basic(duty(9, 0, 6, 2), C_INV, 1, 20, "R7 inverted");
    run_basic(duty(9, 0, 6, 2), C_OD, 1, 20, "R8 open-drain");
    run_basic(duty(9, 0, 6, 2), C_OD | C_INV, 1, 20, "R8 open-drain inverted");

    // R4 prescaler: H=1,L=2 -> 6 ; H=3,L=0 -> 8
    run_basic(duty(3, 0, 3, 1), 32'h0000_0102, 6, 60, "R4 prescale 2x3");
    run_basic(duty(2, 0, 1, 0), 32'h0000_0300, 8, 48, "R4 prescale 8");

    // R5 pin disabled
    do_reset();
    wr(1, duty(9, 0, 6, 0));
    wr(0, C_CLK | C_LVL | C_INV);
    push_const(1'b0, 1'b1, 10, "R5 pin off");
    drain();

    // R6 static level, then resume from the frozen state
    do_reset();
    wr(1, duty(9, 0, 6, 2));
    wr(0, C_PIN | C_LVL);
    push_const(1'b1, 1'b0, 8, "R6 static high");
    drain();
    wr(0, C_PIN | C_LVL | C_INV);
    push_const(1'b0, 1'b0, 8, "R6 static inverted");
    drain();
    wr(0, C_RUN);
    push_wave(duty(9, 0, 6, 2), duty(9, 0, 6, 2), 99, 1, 20, 0, 0, "R6 resume");
    drain();

    // R9 synchronised update: new duty from next counter zero (k=10)
    do_reset();
    wr(1, duty(9, 0, 5, 0));
    wr(0, C_RUN);
    push_wave(duty(9, 0, 5, 0), duty(9, 0, 7, 0), 10, 1, 25, 0, 0, "R9 sync update");
    repeat (2) @(posedge clk);
    wr(1, duty(9, 0, 7, 0));
    drain();

    // R9 unsynchronised: used from the cycle after the write (k=4)
    do_reset();
    wr(1, duty(9, 0, 5, 0));
    wr(0, C_RUN | C_SDIS);
    push_wave(duty(9, 0, 5, 0), duty(9, 0, 7, 0), 4, 1, 25, 0, 0, "R9 immediate update");
    repeat (2) @(posedge clk);
    wr(1, duty(9, 0, 7, 0));
    drain();

    // R10 watchdog replaces falling point, applied at next cycle start
    do_reset();
    wr(1, duty(9, 3, 7, 0));
    wr(0, C_RUN | C_WEN | C_WSEL);
    push_wave(duty(9, 3, 7, 0), duty(9, 3, 3, 0), 10, 1, 20, 0, 0, "R10 wdt falling");
    repeat (2) @(posedge clk);
    pulse_wdt();
    drain();
    rd(1, duty(9, 3, 3, 0), "R10 falling readback");

    // R10 rising select, then event ignored when disabled
    do_reset();
    wr(1, duty(9, 5, 7, 0));
    wr(0, C_WEN);
    pulse_wdt();
    rd(1, duty(9, 5, 7, 5), "R10 rising readback");
    wr(0, 32'h0);
    wr(1, duty(9, 5, 7, 1));
    pulse_wdt();
    rd(1, duty(9, 5, 7, 1), "R10 disabled ignored");

    // R11 register access
    do_reset();
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h000F_FFFF, "R11 ctrl unused bits");
    wr(0, 32'h0005_A3C1);
    rd(0, 32'h0005_A3C1, "R11 ctrl read");
    wr(1, 32'hA5C3_3C5A);
    rd(1, 32'hA5C3_3C5A, "R11 duty read");
    rd(0, 32'h0005_A3C1, "R11 ctrl kept");

    summary();
  end
endmodule